// File: doc/BRIEF.md
# 16-bit Pointer Arithmetic Unit with Signed Displacement

This block is the combinational arithmetic path a small processor core uses for its 16-bit register pairs. In one evaluation it can add one 16-bit pair to another pointer, step a pair up or down by one, or move a pointer by a signed 8-bit displacement. The displacement result is tagged for one of two destinations: back into the stack pointer, or into a separate pair. The surrounding core supplies the operands, the displacement byte, an operation code and the current flag nibble. It takes back the 16-bit result, the merged flag nibble and a per-flag keep mask.

The flag nibble is ordered zero, subtract, half-carry, carry from bit 3 down to bit 0. Each mode treats the flags differently. The pair add keeps zero, clears subtract, and derives half-carry and carry from the upper part of the add. The displacement modes clear zero and subtract and derive half-carry and carry from the low byte only. Stepping touches no flag. The register file and the sequencing of multi-cycle instructions live outside this block.

Top module: `addr_offset_adder`

## Requirements
- R1: With `op_sel` = 0 (pair add), `sum_out` equals (`opnd_a` + `opnd_b`) modulo 65536.
- R2: With `op_sel` = 0, `flags_keep` is 4'b1000. Bit 3 (zero) of `flags_out` equals bit 3 of `flags_in`, even when the sum is zero. Bit 2 (subtract) is 0, bit 1 (half-carry) is the carry out of bit 11 of the add, and bit 0 (carry) is the carry out of bit 15.
- R3: With `op_sel` = 1 (increment), `sum_out` equals `opnd_a` + 1, and 16'hFFFF wraps to 16'h0000.
- R4: With `op_sel` = 2 (decrement), `sum_out` equals `opnd_a` - 1, and 16'h0000 wraps to 16'hFFFF.
- R5: For increment and decrement, `flags_keep` is 4'b1111 and `flags_out` equals `flags_in`.
- R6: With `op_sel` = 3 or 4 (displacement add), `sum_out` equals `opnd_a` plus `disp` read as two's complement, with bits 15..8 of the extended value copied from bit 7, modulo 65536.
- R7: For `op_sel` = 3 or 4, `flags_keep` is 4'b0000, and bits 3 and 2 of `flags_out` are 0 even when the sum is zero. Bit 1 is the carry out of bit 3 and bit 0 is the carry out of bit 7 of the unsigned sum `opnd_a[7:0]` + `disp`.
- R8: `to_sp` is 1 only for `op_sel` = 3. For `op_sel` = 4 it is 0, and the result and flags are the same as for `op_sel` = 3 given the same inputs.
- R9: Codes 5 to 7 are reserved. They give `sum_out` = `opnd_a`, `flags_keep` = 4'b1111, `flags_out` = `flags_in` and `to_sp` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code: 0 pair add, 1 increment, 2 decrement, 3 displacement to stack pointer, 4 displacement to other pair |
| opnd_a | input | 16 | Pointer or pair being modified |
| opnd_b | input | 16 | Second pair for the pair add |
| disp | input | 8 | Signed displacement byte |
| flags_in | input | 4 | Current flags {zero, subtract, half-carry, carry} |
| sum_out | output | 16 | 16-bit result |
| flags_keep | output | 4 | 1 per flag that keeps its old value |
| flags_out | output | 4 | Flags after the operation |
| to_sp | output | 1 | Result is destined for the stack pointer |

## Verification
Two effects can land in the same evaluation: a borrow that a negative displacement carries into the upper byte, and the low-byte carry flags. These flags are computed as if the displacement byte were unsigned. The bench provokes this with a pointer of 16'h0001 and a displacement of 8'hFF. The result is 16'h0000, yet half-carry and carry are both set and zero stays cleared. A matching case for the pair add wraps 16'hFFFF + 1 to zero with the incoming zero flag clear, so zero must stay clear. Every vector, directed or random, is judged against a behavioural model in the bench that uses plain integer arithmetic.

// File: rtl/aa_pkg.sv
package aa_pkg;

    localparam int FLG_Z = 3;
    localparam int FLG_N = 2;
    localparam int FLG_H = 1;
    localparam int FLG_C = 0;
    localparam int FLG_W = 4;

    typedef enum logic [2:0] {
        OP_PAIR_ADD = 3'd0,
        OP_INC      = 3'd1,
        OP_DEC      = 3'd2,
        OP_OFS_SP   = 3'd3,
        OP_OFS_PAIR = 3'd4
    } aa_op_e;

    typedef struct packed {
        logic use_b;
        logic use_ofs;
        logic step_up;
        logic step_dn;
        logic to_sp;
    } aa_ctl_t;

endpackage

// File: rtl/aa_opdecode.sv
module aa_opdecode
    import aa_pkg::*;
(
    input  logic [2:0] op,
    output aa_ctl_t    ctl
);

    always_comb begin
        ctl = '0;
        case (op)
            OP_PAIR_ADD: ctl.use_b   = 1'b1;
            OP_INC:      ctl.step_up = 1'b1;
            OP_DEC:      ctl.step_dn = 1'b1;
            OP_OFS_SP: begin
                ctl.use_ofs = 1'b1;
                ctl.to_sp   = 1'b1;
            end
            OP_OFS_PAIR: ctl.use_ofs = 1'b1;
            default:     ctl = '0;
        endcase
    end

endmodule

// File: rtl/aa_adder16.sv
module aa_adder16
    import aa_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  aa_ctl_t        ctl,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    input  logic [DW-1:0]  d,
    output logic [W-1:0]   sum,
    output logic [W-1:0]   cout
);

    localparam int EXT = W - DW;

    logic [W-1:0] opb;
    logic [W:0]   full;
    logic [W-1:0] cin;

    always_comb begin
        if (ctl.use_b)
            opb = b;
        else if (ctl.use_ofs)
            opb = {{EXT{d[DW-1]}}, d};
        else if (ctl.step_up)
            opb = W'(1);
        else if (ctl.step_dn)
            opb = '1;
        else
            opb = '0;
    end

    assign full = {1'b0, a} + {1'b0, opb};
    assign sum  = full[W-1:0];
    assign cin  = a ^ opb ^ full[W-1:0];

    genvar k;
    generate
        for (k = 0; k < W; k++) begin : g_cout
            if (k == W - 1) begin : g_top
                assign cout[k] = full[W];
            end else begin : g_mid
                assign cout[k] = cin[k+1];
            end
        end
    endgenerate

endmodule

// File: rtl/aa_flaggen.sv
module aa_flaggen
    import aa_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  aa_ctl_t           ctl,
    input  logic [W-1:0]      cout,
    input  logic [FLG_W-1:0]  f_in,
    output logic [FLG_W-1:0]  keep,
    output logic [FLG_W-1:0]  f_out
);

    localparam int HC_PAIR = W - 5;
    localparam int CY_PAIR = W - 1;
    localparam int HC_OFS  = DW / 2 - 1;
    localparam int CY_OFS  = DW - 1;

    logic [FLG_W-1:0] calc;

    always_comb begin
        calc = '0;
        keep = '1;
        if (ctl.use_b) begin
            keep        = '0;
            keep[FLG_Z] = 1'b1;
            calc[FLG_H] = cout[HC_PAIR];
            calc[FLG_C] = cout[CY_PAIR];
        end else if (ctl.use_ofs) begin
            keep        = '0;
            calc[FLG_H] = cout[HC_OFS];
            calc[FLG_C] = cout[CY_OFS];
        end
    end

    genvar i;
    generate
        for (i = 0; i < FLG_W; i++) begin : g_merge
            assign f_out[i] = keep[i] ? f_in[i] : calc[i];
        end
    endgenerate

endmodule

// File: rtl/addr_offset_adder.sv
module addr_offset_adder
    import aa_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input  logic [2:0]       op_sel,
    input  logic [W-1:0]     opnd_a,
    input  logic [W-1:0]     opnd_b,
    input  logic [DW-1:0]    disp,
    input  logic [FLG_W-1:0] flags_in,
    output logic [W-1:0]     sum_out,
    output logic [FLG_W-1:0] flags_keep,
    output logic [FLG_W-1:0] flags_out,
    output logic             to_sp
);

    aa_ctl_t      ctl;
    logic [W-1:0] cout;

    aa_opdecode i_dec (
        .op  (op_sel),
        .ctl (ctl)
    );

    aa_adder16 #(.W(W), .DW(DW)) i_add (
        .ctl  (ctl),
        .a    (opnd_a),
        .b    (opnd_b),
        .d    (disp),
        .sum  (sum_out),
        .cout (cout)
    );

    aa_flaggen #(.W(W), .DW(DW)) i_flg (
        .ctl   (ctl),
        .cout  (cout),
        .f_in  (flags_in),
        .keep  (flags_keep),
        .f_out (flags_out)
    );

    assign to_sp = ctl.to_sp;

endmodule

// File: rtl/aa_checker.sv
module aa_checker
    import aa_pkg::*;
#(
    parameter int W  = 16,
    parameter int DW = 8
) (
    input logic [2:0]       op_sel,
    input logic [W-1:0]     opnd_a,
    input logic [W-1:0]     opnd_b,
    input logic [DW-1:0]    disp,
    input logic [FLG_W-1:0] flags_in,
    input logic [W-1:0]     sum_out,
    input logic [FLG_W-1:0] flags_keep,
    input logic [FLG_W-1:0] flags_out,
    input logic             to_sp
);

    always_comb begin
        if (op_sel == 3'd0) begin
            assert_pair_zero_kept_R2: assert (flags_out[FLG_Z] == flags_in[FLG_Z] && !flags_out[FLG_N])
                else $error("pair add altered zero or set subtract");
        end
        if (op_sel == 3'd1 || op_sel == 3'd2) begin
            assert_step_flags_kept_R5: assert (flags_out == flags_in && flags_keep == 4'b1111)
                else $error("step changed flags");
        end
        if (op_sel == 3'd1) begin
            assert_inc_result_R3: assert (sum_out == W'(opnd_a + W'(1)))
                else $error("increment wrong");
        end
        if (op_sel == 3'd2) begin
            assert_dec_result_R4: assert (sum_out == W'(opnd_a - W'(1)))
                else $error("decrement wrong");
        end
        if (op_sel == 3'd3 || op_sel == 3'd4) begin
            assert_ofs_clear_zn_R7: assert (flags_out[FLG_Z:FLG_N] == 2'b00 && flags_keep == 4'b0000)
                else $error("offset add left zero or subtract");
        end
        if (to_sp) begin
            assert_dest_sp_only_R8: assert (op_sel == 3'd3)
                else $error("stack pointer destination on wrong code");
        end
        if (op_sel > 3'd4) begin
            assert_reserved_pass_R9: assert (sum_out == opnd_a && flags_out == flags_in && !to_sp)
                else $error("reserved code not passive");
        end
    end

endmodule

bind addr_offset_adder aa_checker #(.W(W), .DW(DW)) i_aa_checker (
    .op_sel     (op_sel),
    .opnd_a     (opnd_a),
    .opnd_b     (opnd_b),
    .disp       (disp),
    .flags_in   (flags_in),
    .sum_out    (sum_out),
    .flags_keep (flags_keep),
    .flags_out  (flags_out),
    .to_sp      (to_sp)
);

// File: tb/test_addr_offset_adder.sv
module test_addr_offset_adder;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op_sel = 3'd7;
    logic [15:0] opnd_a = '0;
    logic [15:0] opnd_b = '0;
    logic [7:0]  disp = '0;
    logic [3:0]  flags_in = '0;
    logic [15:0] sum_out;
    logic [3:0]  flags_keep;
    logic [3:0]  flags_out;
    logic        to_sp;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 1'b0;
    string cur_tag = "reset R9";

    always #(CLK_PERIOD/2) clk = ~clk;

    addr_offset_adder i_addr_offset_adder (
        .op_sel     (op_sel),
        .opnd_a     (opnd_a),
        .opnd_b     (opnd_b),
        .disp       (disp),
        .flags_in   (flags_in),
        .sum_out    (sum_out),
        .flags_keep (flags_keep),
        .flags_out  (flags_out),
        .to_sp      (to_sp)
    );

    // behavioural reference, compared at every falling edge
    always @(negedge clk) begin
        int a, b, d, sd, r, h, c, fin, fo, kp, sp;
        if (!done) begin
            a = int'(opnd_a); b = int'(opnd_b); d = int'(disp); fin = int'(flags_in);
            sd = (d >= 128) ? d - 256 : d;
            r = a; fo = fin; kp = 15; sp = 0;
            case (op_sel)
                3'd0: begin
                    r = (a + b) % 65536;
                    h = ((a % 4096) + (b % 4096)) >= 4096 ? 1 : 0;
                    c = (a + b) >= 65536 ? 1 : 0;
                    fo = (fin / 8) * 8 + h * 2 + c;
                    kp = 8;
                end
                3'd1: r = (a + 1) % 65536;
                3'd2: r = (a + 65535) % 65536;
                3'd3, 3'd4: begin
                    r = (a + sd + 65536) % 65536;
                    h = ((a % 16) + (d % 16)) >= 16 ? 1 : 0;
                    c = ((a % 256) + d) >= 256 ? 1 : 0;
                    fo = h * 2 + c;
                    kp = 0;
                    sp = (op_sel == 3'd3) ? 1 : 0;
                end
                default: ;
            endcase
            total++;
            if (int'(sum_out) != r || int'(flags_out) != fo ||
                int'(flags_keep) != kp || int'(to_sp) != sp) begin
                bad++;
                $display("FAIL %s: op=%0d a=%h b=%h d=%h fin=%h got sum=%h f=%h k=%h sp=%0d exp sum=%h f=%h k=%h sp=%0d",
                         cur_tag, op_sel, opnd_a, opnd_b, disp, flags_in,
                         sum_out, flags_out, flags_keep, to_sp, r[15:0], fo[3:0], kp[3:0], sp);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            bad++;
            total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic apply(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                         input logic [7:0] d, input logic [3:0] f, input string tag);
        @(posedge clk);
        #1;
        op_sel = op; opnd_a = a; opnd_b = b; disp = d; flags_in = f; cur_tag = tag;
    endtask

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R1 R2";
            3'd1: return "R3 R5";
            3'd2: return "R4 R5";
            3'd3, 3'd4: return "R6 R7 R8";
            default: return "R9";
        endcase
    endfunction

    initial begin
        // reset phase: reserved code, inputs held, checked as R9
        opnd_a = 16'h1234; flags_in = 4'b0101;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        apply(3'd0, 16'h0FFF, 16'h0001, 8'h00, 4'b1000, "R2 half-carry bit 11");
        apply(3'd0, 16'hFFFF, 16'h0001, 8'h00, 4'b0000, "R1 R2 zero kept clear on wrap");
        apply(3'd0, 16'h1234, 16'h4321, 8'h00, 4'b1111, "R1 plain sum");
        apply(3'd0, 16'h8000, 16'h8000, 8'h00, 4'b0100, "R2 carry bit 15");
        apply(3'd1, 16'hFFFF, 16'h0000, 8'h00, 4'b1010, "R3 wrap");
        apply(3'd1, 16'h00FF, 16'h0000, 8'h00, 4'b1111, "R3 R5 byte carry");
        apply(3'd2, 16'h0000, 16'h0000, 8'h00, 4'b0101, "R4 R5 wrap");
        apply(3'd2, 16'h1000, 16'h0000, 8'h00, 4'b0000, "R4 borrow");
        apply(3'd3, 16'h0001, 16'h0000, 8'hFF, 4'b1100, "R6 R7 R8 negative to zero");
        apply(3'd3, 16'hFFF8, 16'h0000, 8'h08, 4'b0000, "R6 R7 positive wrap");
        apply(3'd4, 16'h1234, 16'h0000, 8'h80, 4'b1111, "R6 R8 most negative");
        apply(3'd4, 16'h00FF, 16'h0000, 8'h01, 4'b1100, "R7 R8 other pair");
        apply(3'd5, 16'hABCD, 16'h1111, 8'h22, 4'b1001, "R9 code 5");
        apply(3'd6, 16'h0000, 16'hFFFF, 8'hFF, 4'b0110, "R9 code 6");
        apply(3'd7, 16'h5555, 16'hAAAA, 8'h7F, 4'b1111, "R9 code 7");
        for (int n = 0; n < 400; n++) begin
            logic [2:0] op;
            op = 3'($urandom_range(0, 7));
            apply(op, 16'($urandom), 16'($urandom), 8'($urandom), 4'($urandom), tag_of(op));
        end
        @(posedge clk);
        @(negedge clk);
        #1;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule